// File: doc/BRIEF.md
# Sprite Range Color-Key Stage

This stage sits in the pixel path of a sprite plane. It takes one pixel per accepted transfer and decides whether that pixel is a key colour that the plane should treat as see-through. Each of the red, green and blue channels is tested against its own inclusive window `[min, max]`. Any channel can be masked out of the test. A pixel is keyed when every unmasked channel lies inside its window. The stage passes the pixel through unchanged and sends a transparency flag with it.

Keying only applies to RGB sources without alpha, at either 16 or 32 bits per pixel. Colour keying on a source with alpha is a programming error. The stage suppresses keying in that case and raises an error flag. For YUV sources, keying is turned off silently. The key settings and the format descriptor are captured when `frame_start` is high, so writes made during a frame only take effect from the next frame.

The pixel interface is valid/ready on both sides and has a single register stage. The upstream side sees `in_ready` high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output pixel and its flag stay frozen and no new pixel is taken.

Top module: `sprite_ckey`

## Requirements
- R1: After reset, `out_valid`, `out_transparent` and `cfg_error` are 0 and keying is disabled. A pixel sent before any `frame_start` is never transparent, whatever the live `cfg_key_en` holds.
- R2: An accepted pixel appears on `out_pixel` unchanged, with `out_valid` high, one cycle after acceptance. `out_transparent` is driven in that same cycle and is never high without `out_valid`.
- R3: Channel windows are inclusive. In 32 bpp, bits [23:16]=R, [15:8]=G and [7:0]=B, and bits [31:24] are ignored. The key min/max words use the same R,G,B byte positions. A channel equal to its min or its max matches. A channel one below min or one above max does not.
- R4: `cfg_chan_mask` bit 2=R, bit 1=G, bit 0=B. A bit set to 1 removes that channel from the test. With all three bits set, every pixel matches.
- R5: `fmt_depth` encoding: 00 = 8 bpp, 01 = 16 bpp (5:6:5), 10 = 32 bpp, 11 = reserved.
- R6: In 16 bpp, bits [15:11] are R, [10:5] are G and [4:0] are B, and bits [31:16] are ignored. Each field is widened to 8 bits by repeating its top bits below it, for example R5 → {R5, R5[4:2]}.
- R7: When `fmt_alpha` is 1, no pixel is transparent. If `cfg_key_en` was 1 at that `frame_start`, `cfg_error` reads 1 from the cycle after it.
- R8: When `fmt_yuv` is 1 (and there is no alpha), no pixel is transparent and `cfg_error` stays 0, even with `cfg_key_en`=1.
- R9: A depth of 8 bpp or reserved disables keying. If the key was enabled at `frame_start`, `cfg_error` is raised.
- R10: The key settings and the format are captured on a cycle with `frame_start`=1. A pixel accepted in that same cycle already uses the new values. Changes made without `frame_start` have no effect on later pixels. `cfg_error` is re-evaluated only at `frame_start`.
- R11: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_pixel`/`out_transparent` hold. `in_ready` is 1 whenever the output register is empty or `out_ready`=1.
- R12: When the key is disabled (`cfg_key_en`=0 at `frame_start`), no pixel is transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Captures key settings and format this cycle |
| cfg_key_en | input | 1 | Key enable |
| cfg_key_min | input | 3*CH_W | Per-channel lower bounds, R,G,B |
| cfg_key_max | input | 3*CH_W | Per-channel upper bounds, R,G,B |
| cfg_chan_mask | input | 3 | Per-channel exclude bits, R,G,B |
| fmt_depth | input | 2 | Source depth code |
| fmt_alpha | input | 1 | Source carries alpha |
| fmt_yuv | input | 1 | Source is YUV |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Stage can take a pixel |
| in_pixel | input | 4*CH_W | Input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | 4*CH_W | Delayed pixel |
| out_transparent | output | 1 | Pixel matched the key |
| cfg_error | output | 1 | Key enabled on an illegal format |

## Verification
The bench builds the stage with the default channel width of 8. At that width the 5- and 6-bit fields of a 16 bpp pixel widen into the same 8-bit range as the key bytes, so 16 bpp pixels can be placed exactly on, inside and just outside a window. Each table row programs a fresh format and key at `frame_start` together with its pixel, which exercises the same-cycle capture rule on every row. Directed sequences then cover a change of settings without `frame_start` and a stall of several cycles on the output side.

// File: rtl/ckey_pkg.sv
package ckey_pkg;

  localparam int unsigned NUM_CH = 3;

  typedef enum logic [1:0] {
    DEPTH_8   = 2'b00,
    DEPTH_16  = 2'b01,
    DEPTH_32  = 2'b10,
    DEPTH_RSV = 2'b11
  } depth_e;

  // 16 bpp field layout, index 0 = B, 1 = G, 2 = R
  localparam int unsigned LO16 [NUM_CH] = '{0, 5, 11};
  localparam int unsigned W16  [NUM_CH] = '{5, 6, 5};

  function automatic logic depth_keyable(input logic [1:0] d);
    return (d == DEPTH_16) || (d == DEPTH_32);
  endfunction

endpackage

// File: rtl/ckey_cfg.sv
module ckey_cfg
  import ckey_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int KEY_W = NUM_CH * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             key_en,
  input  logic [KEY_W-1:0] key_min,
  input  logic [KEY_W-1:0] key_max,
  input  logic [2:0]       chan_mask,
  input  logic [1:0]       depth,
  input  logic             alpha,
  input  logic             yuv,
  output logic             eff_on,
  output logic [KEY_W-1:0] eff_min,
  output logic [KEY_W-1:0] eff_max,
  output logic [2:0]       eff_mask,
  output logic [1:0]       eff_depth,
  output logic             err
);

  logic             live_on, live_err;
  logic             lat_on;
  logic [KEY_W-1:0] lat_min, lat_max;
  logic [2:0]       lat_mask;
  logic [1:0]       lat_depth;

  always_comb begin
    live_on  = key_en && depth_keyable(depth) && !alpha && !yuv;
    live_err = key_en && (alpha || !depth_keyable(depth));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_on    <= 1'b0;
      lat_min   <= '0;
      lat_max   <= '0;
      lat_mask  <= '0;
      lat_depth <= DEPTH_32;
      err       <= 1'b0;
    end else if (frame_start) begin
      lat_on    <= live_on;
      lat_min   <= key_min;
      lat_max   <= key_max;
      lat_mask  <= chan_mask;
      lat_depth <= depth;
      err       <= live_err;
    end
  end

  // settings written with frame_start apply to a pixel in the same cycle
  always_comb begin
    eff_on    = frame_start ? live_on   : lat_on;
    eff_min   = frame_start ? key_min   : lat_min;
    eff_max   = frame_start ? key_max   : lat_max;
    eff_mask  = frame_start ? chan_mask : lat_mask;
    eff_depth = frame_start ? depth     : lat_depth;
  end

endmodule

// File: rtl/ckey_unpack.sv
module ckey_unpack
  import ckey_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int KEY_W = NUM_CH * CH_W
) (
  input  logic [KEY_W-1:0] pix,
  input  logic [1:0]       depth,
  output logic [KEY_W-1:0] chans
);

  logic [KEY_W-1:0] wide16;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned LO = LO16[c];
    localparam int unsigned W  = W16[c];
    for (genvar i = 0; i < CH_W; i++) begin : g_bit
      localparam int unsigned SRC = LO + W - 1 - ((CH_W - 1 - i) % W);
      assign wide16[c*CH_W + i] = pix[SRC];
    end
  end

  assign chans = (depth == DEPTH_16) ? wide16 : pix;

endmodule

// File: rtl/ckey_match.sv
module ckey_match
  import ckey_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int KEY_W = NUM_CH * CH_W
) (
  input  logic [KEY_W-1:0]  chans,
  input  logic [KEY_W-1:0]  lo,
  input  logic [KEY_W-1:0]  hi,
  input  logic [NUM_CH-1:0] mask,
  output logic              hit
);

  logic [NUM_CH-1:0] ch_ok;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    logic [CH_W-1:0] v, l, h;
    assign v = chans[c*CH_W +: CH_W];
    assign l = lo[c*CH_W +: CH_W];
    assign h = hi[c*CH_W +: CH_W];
    assign ch_ok[c] = mask[c] || ((v >= l) && (v <= h));
  end

  assign hit = &ch_ok;

endmodule

// File: rtl/sprite_ckey.sv
module sprite_ckey
  import ckey_pkg::*;
#(
  parameter int CH_W = 8,
  localparam int KEY_W = NUM_CH * CH_W,
  localparam int PIX_W = (NUM_CH + 1) * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             cfg_key_en,
  input  logic [KEY_W-1:0] cfg_key_min,
  input  logic [KEY_W-1:0] cfg_key_max,
  input  logic [2:0]       cfg_chan_mask,
  input  logic [1:0]       fmt_depth,
  input  logic             fmt_alpha,
  input  logic             fmt_yuv,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel,
  output logic             out_transparent,
  output logic             cfg_error
);

  logic             k_on;
  logic [KEY_W-1:0] k_min, k_max, chans;
  logic [2:0]       k_mask;
  logic [1:0]       k_depth;
  logic             hit, take;

  ckey_cfg #(.CH_W(CH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .key_en(cfg_key_en), .key_min(cfg_key_min), .key_max(cfg_key_max),
    .chan_mask(cfg_chan_mask), .depth(fmt_depth), .alpha(fmt_alpha),
    .yuv(fmt_yuv), .eff_on(k_on), .eff_min(k_min), .eff_max(k_max),
    .eff_mask(k_mask), .eff_depth(k_depth), .err(cfg_error)
  );

  ckey_unpack #(.CH_W(CH_W)) u_unpack (
    .pix(in_pixel[KEY_W-1:0]), .depth(k_depth), .chans(chans)
  );

  ckey_match #(.CH_W(CH_W)) u_match (
    .chans(chans), .lo(k_min), .hi(k_max), .mask(k_mask), .hit(hit)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_pixel       <= '0;
      out_transparent <= 1'b0;
    end else if (take) begin
      out_valid       <= 1'b1;
      out_pixel       <= in_pixel;
      out_transparent <= hit && k_on;
    end else if (out_ready) begin
      out_valid       <= 1'b0;
      out_transparent <= 1'b0;
    end
  end

endmodule

// File: rtl/ckey_chk.sv
module ckey_chk #(
  parameter int PIX_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             cfg_key_en,
  input logic [1:0]       fmt_depth,
  input logic             fmt_alpha,
  input logic             fmt_yuv,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] in_pixel,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pixel,
  input logic             out_transparent,
  input logic             cfg_error
);

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_pixel == $past(in_pixel));

  p_flag_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_transparent |-> out_valid);

  p_alpha_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && cfg_key_en && fmt_alpha |=> cfg_error);

  p_alpha_nokey_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && fmt_alpha && in_valid && in_ready |=> !out_transparent);

  p_yuv_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && fmt_yuv && !fmt_alpha && fmt_depth inside {2'b01, 2'b10}
    |=> !cfg_error);

  p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !cfg_key_en && in_valid && in_ready |=> !out_transparent);

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel)
                                && $stable(out_transparent));

  p_err_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cfg_error));

endmodule

bind sprite_ckey ckey_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .cfg_key_en(cfg_key_en), .fmt_depth(fmt_depth), .fmt_alpha(fmt_alpha),
  .fmt_yuv(fmt_yuv), .in_valid(in_valid), .in_ready(in_ready),
  .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
  .out_pixel(out_pixel), .out_transparent(out_transparent),
  .cfg_error(cfg_error)
);

// File: tb/sim_sprite_ckey.sv
module sim_sprite_ckey;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        cfg_key_en = 1'b0;
  logic [23:0] cfg_key_min = '0;
  logic [23:0] cfg_key_max = '0;
  logic [2:0]  cfg_chan_mask = '0;
  logic [1:0]  fmt_depth = 2'b10;
  logic        fmt_alpha = 1'b0;
  logic        fmt_yuv = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pixel = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pixel;
  logic        out_transparent;
  logic        cfg_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sprite_ckey u0 (.*);

  localparam logic [23:0] KMIN = 24'h0A1E32; // R10 G30 B50
  localparam logic [23:0] KMAX = 24'h14283C; // R20 G40 B60

  typedef struct packed {
    logic [1:0]  depth;
    logic        alpha;
    logic        yuv;
    logic        en;
    logic [2:0]  mask;
    logic [31:0] pix;
    logic        exp_t;
    logic        exp_e;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 32'hAB0F2337, 1'b1, 1'b0}, // R3 inside, top byte ignored
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 32'h000A1E32, 1'b1, 1'b0}, // R3 at min
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 32'h0014283C, 1'b1, 1'b0}, // R3 at max
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 32'h00091E32, 1'b0, 1'b0}, // R3 R below
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 32'h0015283C, 1'b0, 1'b0}, // R3 R above
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b000, 32'h000F233D, 1'b0, 1'b0}, // R3 B above
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b100, 32'h00FF2337, 1'b1, 1'b0}, // R4 R masked
    '{2'b10, 1'b0, 1'b0, 1'b1, 3'b111, 32'h00123456, 1'b1, 1'b0}, // R4 all masked
    '{2'b10, 1'b0, 1'b0, 1'b0, 3'b000, 32'h000F2337, 1'b0, 1'b0}, // R12 disabled
    '{2'b10, 1'b1, 1'b0, 1'b1, 3'b000, 32'h000F2337, 1'b0, 1'b1}, // R7 alpha
    '{2'b10, 1'b0, 1'b1, 1'b1, 3'b000, 32'h000F2337, 1'b0, 1'b0}, // R8 yuv
    '{2'b00, 1'b0, 1'b0, 1'b1, 3'b000, 32'h000F2337, 1'b0, 1'b1}, // R9 8 bpp
    '{2'b01, 1'b0, 1'b0, 1'b1, 3'b000, 32'h00001127, 1'b1, 1'b0}, // R6 16bpp 16,36,57
    '{2'b01, 1'b0, 1'b0, 1'b1, 3'b000, 32'h00000927, 1'b0, 1'b0}, // R6 16bpp R=8
    '{2'b01, 1'b0, 1'b0, 1'b1, 3'b000, 32'hABCD1127, 1'b1, 1'b0}  // R6 upper ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one pixel at a falling edge, sample at the next falling edge
  task automatic send(input logic [31:0] pix, input logic fs);
    @(negedge clk);
    in_pixel = pix; in_valid = 1'b1; frame_start = fs;
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 out_transparent", {31'b0, out_transparent}, 32'd0);
    chk("R1 cfg_error", {31'b0, cfg_error}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 in_ready idle", {31'b0, in_ready}, 32'd1);
    // R1 live enable not yet captured
    cfg_key_en = 1'b1; cfg_key_min = KMIN; cfg_key_max = KMAX;
    send(32'h000F2337, 1'b0);
    chk("R1 no key before frame_start", {31'b0, out_transparent}, 32'd0);
    chk("R2 out_valid", {31'b0, out_valid}, 32'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      fmt_depth = VT[i].depth; fmt_alpha = VT[i].alpha; fmt_yuv = VT[i].yuv;
      cfg_key_en = VT[i].en; cfg_chan_mask = VT[i].mask;
      cfg_key_min = KMIN; cfg_key_max = KMAX;
      send(VT[i].pix, 1'b1);
      chk($sformatf("R2 vec%0d pixel", i), out_pixel, VT[i].pix);
      chk($sformatf("R2 vec%0d valid", i), {31'b0, out_valid}, 32'd1);
      chk($sformatf("R5 vec%0d transparent", i), {31'b0, out_transparent}, {31'b0, VT[i].exp_t});
      chk($sformatf("R7 vec%0d cfg_error", i), {31'b0, cfg_error}, {31'b0, VT[i].exp_e});
    end

    // R10 settings change without frame_start is not seen
    fmt_depth = 2'b10; fmt_alpha = 1'b0; fmt_yuv = 1'b0;
    cfg_key_en = 1'b1; cfg_chan_mask = 3'b000; cfg_key_min = KMIN; cfg_key_max = KMAX;
    send(32'h000F2337, 1'b1);
    chk("R10 first frame keyed", {31'b0, out_transparent}, 32'd1);
    cfg_key_en = 1'b0; fmt_alpha = 1'b1;
    send(32'h000F2337, 1'b0);
    chk("R10 mid-frame write ignored", {31'b0, out_transparent}, 32'd1);
    chk("R10 error not re-evaluated", {31'b0, cfg_error}, 32'd0);
    cfg_key_en = 1'b1;
    send(32'h000F2337, 1'b1);
    chk("R7 alpha at next frame", {31'b0, out_transparent}, 32'd0);
    chk("R7 error raised", {31'b0, cfg_error}, 32'd1);
    fmt_alpha = 1'b0;
    send(32'h000F2337, 1'b1);
    chk("R7 error clears", {31'b0, cfg_error}, 32'd0);
    chk("R10 keyed again", {31'b0, out_transparent}, 32'd1);

    // R11 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_pixel = 32'h000F2337; in_valid = 1'b1; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; in_pixel = 32'h00010101;
    chk("R11 held valid", {31'b0, out_valid}, 32'd1);
    chk("R11 in_ready low", {31'b0, in_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 pixel held", out_pixel, 32'h000F2337);
      chk("R11 flag held", {31'b0, out_transparent}, 32'd1);
      chk("R11 stall", {31'b0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 next pixel after release", out_pixel, 32'h00010101);
    chk("R11 next flag", {31'b0, out_transparent}, 32'd0);
    @(negedge clk);
    chk("R11 drained", {31'b0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule